// File: doc/BRIEF.md
# Descriptor Fetch Sequencer

This block chains DMA transfers by loading transfer descriptors from memory. A fetch starts when software pulses a start input, or when the DMA engine asks for its next job while the DMA is enabled. The block then reads four words through a simple bus-master read port, one request at a time. The words are a control word, a buffer address, a pointer to the next descriptor and a word that carries the valid flag. When the descriptor is valid, the block hands the control word and the buffer address to the DMA engine with a one-cycle start pulse. It also adopts the fetched next pointer for the following fetch.

A descriptor whose flag is clear raises a one-cycle "next" event. In stop mode the block then disables the DMA and raises a done event, and it does nothing more until software starts it again. In polling mode it waits a programmable number of cycles and fetches the same descriptor again. This repeats until the flag is found set.

A bus error on any descriptor read halts the sequencer, disables the DMA, sets a sticky error flag and records the address of the failing read. Software must clear the flag, rewrite the descriptor pointer and start the block again.

Top module: `desc_fetch`

## Requirements
- R1: After reset: dma_en, err_flag, m_req, eng_start, next_evt and done_evt are all 0.
- R2: A fetch issues four reads in order at desc_ptr+0, +4, +8 and +12. Each read holds m_req high with a stable m_addr until the cycle in which m_done is high.
- R3: The flag is bit 0 of the word read at +12. If that bit is 1, then in the cycle after the final response eng_ctl and eng_addr show the words read at +0 and +4, desc_ptr shows the word read at +8, and eng_start is high for exactly one cycle.
- R4: If that bit is 0, next_evt is high for exactly one cycle, in the cycle after the final response.
- R5: In stop mode (cfg_poll=0), an invalid descriptor clears dma_en and pulses done_evt in the same cycle as next_evt. After that, no read is issued until sw_start.
- R6: In polling mode (cfg_poll=1), after an invalid descriptor m_req stays low for exactly cfg_dly+1 cycles, counted from the next_evt cycle. The same four addresses are then read again, and dma_en stays 1.
- R7: A response with m_err high ends the fetch. In the next cycle m_req is 0, dma_en is 0, err_flag is 1 and fault_addr holds the address of the failing read.
- R8: While err_flag is 1, sw_start and eng_req start no read. An err_clr pulse clears err_flag and leaves dma_en at 0. A later sw_start fetches from the newly written pointer.
- R9: eng_req starts a fetch only when dma_en is 1 and no fetch is in progress. Otherwise it has no effect.
- R10: A pointer written through ptr_wr is stored with its two low bits cleared. The same applies to an adopted next pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_start | input | 1 | Software start pulse; enables the DMA and begins a fetch |
| eng_req | input | 1 | DMA engine request for the next descriptor |
| err_clr | input | 1 | Software clear of the error flag |
| cfg_poll | input | 1 | 1 = poll on invalid descriptor, 0 = stop |
| cfg_dly | input | DLY_W | Poll delay; the gap is cfg_dly+1 cycles |
| ptr_wr | input | 1 | Write strobe for the descriptor pointer (idle or error state) |
| ptr_wdata | input | AW | Descriptor pointer value to write |
| m_req | output | 1 | Read request to memory |
| m_addr | output | AW | Read address |
| m_done | input | 1 | Read response valid |
| m_err | input | 1 | Read response is an error |
| m_rdata | input | DW | Read response data |
| dma_en | output | 1 | DMA enable |
| err_flag | output | 1 | Sticky bus error flag |
| desc_ptr | output | AW | Current descriptor pointer |
| fault_addr | output | AW | Address of the last failing read |
| eng_ctl | output | DW | Control word loaded into the engine |
| eng_addr | output | AW | Buffer address loaded into the engine |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| next_evt | output | 1 | One-cycle invalid-descriptor event |
| done_evt | output | 1 | One-cycle stop-mode done event |

## Verification
Every result is registered, so it appears in the cycle after the edge at which the final response, the error response or the control pulse is taken. A read request appears in the cycle after the edge that takes the triggering start. The bench drives inputs and samples outputs on the falling edge. It therefore reads each event in the first falling-edge sample after the triggering rising edge, and confirms in the sample after that that each pulse has dropped. The poll gap is measured by counting falling-edge samples with m_req low, starting at the sample in which next_evt is seen; that count must equal cfg_dly+1. The memory model pops an expected address from a queue at every response it returns, so the read order is checked as the reads happen.

// File: rtl/dfetch_pkg.sv
package dfetch_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WAIT,
        ST_ERR
    } fetch_state_t;

    typedef enum logic [1:0] {
        W_CTL,
        W_BUF,
        W_NXT,
        W_FLAG
    } word_sel_t;

    localparam int FLAG_BIT   = 0;
    localparam int WORD_SHIFT = 2;

    function automatic word_sel_t sel_next(input word_sel_t s);
        return word_sel_t'(s + 2'd1);
    endfunction

endpackage

// File: rtl/dfetch_delay.sv
module dfetch_delay #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    input  logic             run,
    output logic             zero
);
    logic [DLY_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/dfetch_capture.sv
module dfetch_capture
    import dfetch_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      we,
    input  word_sel_t sel,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] ctl_q,
    output logic [DW-1:0] buf_q,
    output logic [DW-1:0] nxt_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            buf_q <= '0;
            nxt_q <= '0;
        end else if (we) begin
            case (sel)
                W_CTL:   ctl_q <= wdata;
                W_BUF:   buf_q <= wdata;
                W_NXT:   nxt_q <= wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/desc_fetch.sv
module desc_fetch
    import dfetch_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_start,
    input  logic             eng_req,
    input  logic             err_clr,
    input  logic             cfg_poll,
    input  logic [DLY_W-1:0] cfg_dly,
    input  logic             ptr_wr,
    input  logic [AW-1:0]    ptr_wdata,
    output logic             m_req,
    output logic [AW-1:0]    m_addr,
    input  logic             m_done,
    input  logic             m_err,
    input  logic [DW-1:0]    m_rdata,
    output logic             dma_en,
    output logic             err_flag,
    output logic [AW-1:0]    desc_ptr,
    output logic [AW-1:0]    fault_addr,
    output logic [DW-1:0]    eng_ctl,
    output logic [AW-1:0]    eng_addr,
    output logic             eng_start,
    output logic             next_evt,
    output logic             done_evt
);
    localparam logic [AW-1:0] ALIGN_MASK = ~AW'((1 << WORD_SHIFT) - 1);

    fetch_state_t state;
    word_sel_t    sel;
    logic [DW-1:0] cap_ctl, cap_buf, cap_nxt;
    logic go, resp_ok, resp_bad, last, flag_ok, dly_zero, dly_load;

    assign m_req    = (state == ST_READ);
    assign m_addr   = desc_ptr + {{(AW-WORD_SHIFT-2){1'b0}}, sel, {WORD_SHIFT{1'b0}}};
    assign resp_ok  = m_req && m_done && !m_err;
    assign resp_bad = m_req && m_done && m_err;
    assign last     = (sel == W_FLAG);
    assign flag_ok  = m_rdata[FLAG_BIT];
    assign go       = (state == ST_IDLE) &&
                      ((sw_start && !err_flag) || (eng_req && dma_en));
    assign dly_load = resp_ok && last && !flag_ok && cfg_poll;

    dfetch_capture #(.DW(DW)) u_cap (
        .clk(clk), .rst(rst), .we(resp_ok), .sel(sel), .wdata(m_rdata),
        .ctl_q(cap_ctl), .buf_q(cap_buf), .nxt_q(cap_nxt)
    );

    dfetch_delay #(.DLY_W(DLY_W)) u_dly (
        .clk(clk), .rst(rst), .load(dly_load), .load_val(cfg_dly),
        .run(state == ST_WAIT), .zero(dly_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            sel        <= W_CTL;
            dma_en     <= 1'b0;
            err_flag   <= 1'b0;
            desc_ptr   <= '0;
            fault_addr <= '0;
            eng_ctl    <= '0;
            eng_addr   <= '0;
            eng_start  <= 1'b0;
            next_evt   <= 1'b0;
            done_evt   <= 1'b0;
        end else begin
            eng_start <= 1'b0;
            next_evt  <= 1'b0;
            done_evt  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (ptr_wr) desc_ptr <= ptr_wdata & ALIGN_MASK;
                    if (go) begin
                        if (sw_start) dma_en <= 1'b1;
                        sel   <= W_CTL;
                        state <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (resp_bad) begin
                        fault_addr <= m_addr;
                        err_flag   <= 1'b1;
                        dma_en     <= 1'b0;
                        sel        <= W_CTL;
                        state      <= ST_ERR;
                    end else if (resp_ok) begin
                        if (!last) begin
                            sel <= sel_next(sel);
                        end else begin
                            sel <= W_CTL;
                            if (flag_ok) begin
                                eng_ctl   <= cap_ctl;
                                eng_addr  <= cap_buf[AW-1:0];
                                desc_ptr  <= cap_nxt[AW-1:0] & ALIGN_MASK;
                                eng_start <= 1'b1;
                                state     <= ST_IDLE;
                            end else begin
                                next_evt <= 1'b1;
                                if (cfg_poll) begin
                                    state <= ST_WAIT;
                                end else begin
                                    dma_en   <= 1'b0;
                                    done_evt <= 1'b1;
                                    state    <= ST_IDLE;
                                end
                            end
                        end
                    end
                end
                ST_WAIT: begin
                    if (dly_zero) state <= ST_READ;
                end
                ST_ERR: begin
                    if (ptr_wr) desc_ptr <= ptr_wdata & ALIGN_MASK;
                    if (err_clr) begin
                        err_flag <= 1'b0;
                        state    <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/desc_fetch_chk.sv
module desc_fetch_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          err_clr,
    input logic          m_req,
    input logic [AW-1:0] m_addr,
    input logic          m_done,
    input logic          m_err,
    input logic          dma_en,
    input logic          err_flag,
    input logic [AW-1:0] fault_addr,
    input logic          eng_start,
    input logic          next_evt,
    input logic          done_evt
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!dma_en && !err_flag && !m_req && !eng_start && !next_evt && !done_evt));

    a_r2_hold_request: assert property (@(posedge clk) disable iff (rst)
        (m_req && !m_done) |=> (m_req && $stable(m_addr)));

    a_r3_start_single: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start);

    a_r4_next_single: assert property (@(posedge clk) disable iff (rst)
        next_evt |=> !next_evt);

    a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({eng_start, next_evt}));

    a_r5_done_with_next: assert property (@(posedge clk) disable iff (rst)
        done_evt |-> (next_evt && !dma_en));

    a_r7_error_capture: assert property (@(posedge clk) disable iff (rst)
        (m_req && m_done && m_err) |=>
            (!m_req && !dma_en && err_flag && fault_addr == $past(m_addr)));

    a_r8_error_hold: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !err_clr) |=> (err_flag && !m_req));
endmodule

bind desc_fetch desc_fetch_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .err_clr(err_clr), .m_req(m_req), .m_addr(m_addr),
    .m_done(m_done), .m_err(m_err), .dma_en(dma_en), .err_flag(err_flag),
    .fault_addr(fault_addr), .eng_start(eng_start), .next_evt(next_evt),
    .done_evt(done_evt)
);

// File: tb/desc_fetch_test.sv
module desc_fetch_test;
    localparam int AW = 32, DW = 32, DLY_W = 8;

    logic clk = 0, rst = 1;
    logic sw_start = 0, eng_req = 0, err_clr = 0, cfg_poll = 0, ptr_wr = 0;
    logic [DLY_W-1:0] cfg_dly = '0;
    logic [AW-1:0] ptr_wdata = '0;
    logic m_req, m_done = 0, m_err = 0;
    logic [AW-1:0] m_addr, desc_ptr, fault_addr, eng_addr;
    logic [DW-1:0] m_rdata = '0, eng_ctl;
    logic dma_en, err_flag, eng_start, next_evt, done_evt;

    int checks = 0, fails = 0;
    logic [31:0] mem [0:63];
    logic [31:0] err_at = 32'hFFFF_FFFF;
    logic [31:0] exp_q [$];
    bit finished = 0;

    always #2 clk = ~clk;

    desc_fetch #(.AW(AW), .DW(DW), .DLY_W(DLY_W)) uut (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model and read-order scoreboard (R2)
    initial begin
        int lat = 0;
        forever begin
            @(negedge clk);
            if (m_done) begin
                m_done = 0; m_err = 0; lat = 0;
            end else if (m_req && !rst) begin
                if (lat == 1) begin
                    if (exp_q.size() == 0) begin
                        check(0, "R2 unexpected read", m_addr, 0);
                    end else begin
                        logic [31:0] e;
                        e = exp_q.pop_front();
                        check(m_addr == e, "R2 read order", m_addr, e);
                    end
                    m_rdata = mem[m_addr[7:2]];
                    m_err   = (m_addr == err_at);
                    m_done  = 1;
                end else lat++;
            end
        end
    end

    task automatic push_desc(input logic [31:0] base, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(base + 32'(4 * i));
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: sw_start = 1;
            1: eng_req  = 1;
            default: err_clr = 1;
        endcase
        @(negedge clk);
        sw_start = 0; eng_req = 0; err_clr = 0;
    endtask

    // waits at negedges until the selected output is high
    task automatic wait_hi(input int which, input string req);
        bit seen = 0;
        for (int i = 0; i < 300 && !seen; i++) begin
            case (which)
                0: seen = eng_start;
                1: seen = next_evt;
                default: seen = err_flag;
            endcase
            if (!seen) @(negedge clk);
        end
        check(seen, req, 0, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int gap;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        mem[4]  = 32'h0000_00A5; mem[5]  = 32'h0000_1000; mem[6]  = 32'h0000_0040; mem[7]  = 32'h1;
        mem[16] = 32'h0000_005A; mem[17] = 32'h0000_2000; mem[18] = 32'h0000_0082; mem[19] = 32'h0;
        mem[32] = 32'h0000_0077; mem[33] = 32'h0000_3000; mem[34] = 32'h0000_0010; mem[35] = 32'h1;

        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(!dma_en && !err_flag && !m_req && !eng_start && !next_evt && !done_evt,
              "R1 reset state", {dma_en, err_flag, m_req, eng_start, next_evt, done_evt}, 0);

        // R10: pointer write with misaligned low bits
        ptr_wr = 1; ptr_wdata = 32'h13;
        @(negedge clk); ptr_wr = 0;
        check(desc_ptr == 32'h10, "R10 pointer aligned", desc_ptr, 32'h10);

        // R3: valid descriptor via software start
        push_desc(32'h10, 4);
        pulse(0);
        wait_hi(0, "R3 start pulse seen");
        check(eng_ctl == 32'hA5, "R3 control word", eng_ctl, 32'hA5);
        check(eng_addr == 32'h1000, "R3 buffer address", eng_addr, 32'h1000);
        check(desc_ptr == 32'h40, "R3 next pointer adopted", desc_ptr, 32'h40);
        check(dma_en, "R3 dma enabled", dma_en, 1);
        @(negedge clk);
        check(!eng_start, "R3 start one cycle", eng_start, 0);
        check(exp_q.size() == 0, "R2 all four reads done", exp_q.size(), 0);

        // R4/R5: invalid descriptor in stop mode via engine request (R9)
        push_desc(32'h40, 4);
        pulse(1);
        wait_hi(1, "R4 next event seen");
        check(done_evt, "R5 done with next", done_evt, 1);
        check(!dma_en, "R5 dma disabled", dma_en, 0);
        check(desc_ptr == 32'h40, "R4 pointer kept", desc_ptr, 32'h40);
        @(negedge clk);
        check(!next_evt && !done_evt, "R4 events one cycle", {next_evt, done_evt}, 0);
        pulse(1);
        gap = 0;
        for (int i = 0; i < 10; i++) begin @(negedge clk); if (m_req) gap++; end
        check(gap == 0, "R9 eng_req ignored while disabled", gap, 0);
        check(gap == 0 && !dma_en, "R5 no read until start", dma_en, 0);

        // R6: polling mode
        cfg_poll = 1; cfg_dly = 8'd3;
        push_desc(32'h40, 4); push_desc(32'h40, 4);
        pulse(0);
        wait_hi(1, "R6 first poll invalid");
        mem[19] = 32'h1;
        gap = 0;
        for (int i = 0; i < 50 && !m_req; i++) begin gap++; @(negedge clk); end
        check(gap == 4, "R6 poll gap cfg_dly+1", gap, 4);
        check(dma_en, "R6 dma stays enabled", dma_en, 1);
        wait_hi(0, "R6 refetch finds valid");
        check(eng_ctl == 32'h5A && eng_addr == 32'h2000, "R6 refetched values", eng_ctl, 32'h5A);
        check(desc_ptr == 32'h80, "R10 adopted pointer aligned", desc_ptr, 32'h80);
        @(negedge clk);

        // R7: bus error on third word
        err_at = 32'h88;
        push_desc(32'h80, 3);
        pulse(1);
        wait_hi(2, "R7 error flag set");
        check(!dma_en, "R7 dma disabled", dma_en, 0);
        check(fault_addr == 32'h88, "R7 fault address", fault_addr, 32'h88);
        check(!m_req, "R7 request dropped", m_req, 0);

        // R8: ignored starts while in error, then recovery
        pulse(0); pulse(1);
        gap = 0;
        for (int i = 0; i < 5; i++) begin @(negedge clk); if (m_req) gap++; end
        check(gap == 0 && err_flag, "R8 starts ignored in error", gap, 0);
        pulse(2);
        check(!err_flag && !dma_en, "R8 error cleared, still disabled", {err_flag, dma_en}, 0);
        err_at = 32'hFFFF_FFFF;
        ptr_wr = 1; ptr_wdata = 32'h10;
        @(negedge clk); ptr_wr = 0;
        push_desc(32'h10, 4);
        pulse(0);
        wait_hi(0, "R8 restart after reprogram");
        check(eng_ctl == 32'hA5 && desc_ptr == 32'h40, "R8 restart values", eng_ctl, 32'hA5);
        check(exp_q.size() == 0, "R2 queue drained", exp_q.size(), 0);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule